// File: doc/BRIEF.md
# Tag-Matched Two-Level Multicast Delivery Grid

This block hands one data word per cycle from a single buffer-side source to a rectangular grid of consumers (12 rows by 14 columns by default). Each word travels with two tags. The row tag picks rows on a vertical bus. The column tag picks endpoints on each row's horizontal bus. Every row and every endpoint has a controller with a programmable ID. A controller passes the word on only when the incoming tag equals its ID. Programming many controllers with the same ID makes one word land on many endpoints in the same cycle. Giving every controller a distinct ID gives point-to-point delivery.

The IDs are loaded through a serial shift chain. The chain is loaded while the bus is idle. The all-ones ID is reserved: a controller that holds it never matches, and no tag carrying that value ever hits. A per-endpoint enable stands in for clock gating of unused consumers, and blocks delivery to them. A delivered word sits in a registered output stage. Each endpoint holds its own valid flag until that endpoint signals ready. The source is stalled until every endpoint that holds a pending word can take it, so no matched endpoint ever loses a word.

Top module: `tagcast_grid`

## Requirements
- R1: After reset no endpoint valid is high, src_ready is high, and every ID holds the reserved value 4'hF, so an accepted transfer reaches no endpoint.
- R2: Each cycle with cfg_shift high shifts cfg_id into chain position 0, and every position p moves to p+1. Position p < ROWS is the ID of row p. Position ROWS + r*COLS + c is the column ID of endpoint (r, c).
- R3: While cfg_shift is high, src_ready is low, no transfer is accepted, and no endpoint receives a word.
- R4: A transfer reaches endpoint (r, c), bit r*COLS + c of ep_valid, if and only if all of these hold: the row tag equals the ID of row r, the column tag equals the column ID of (r, c), and bit r*COLS + c of pe_enable is set.
- R5: A single transfer reaches all matching endpoints in the same cycle. Shared IDs give multicast to many endpoints. Unique IDs give delivery to exactly one endpoint.
- R6: A word accepted at a clock edge (src_valid and src_ready both high) shows on ep_valid and ep_data right after that edge.
- R7: Each endpoint's valid stays high until that endpoint's ep_ready is high at a clock edge. ep_data stays stable while any valid is pending and no new word is accepted.
- R8: src_ready is low while any pending endpoint has ep_ready low. It rises in the same cycle that all pending endpoints become ready.
- R9: A transfer that matches no endpoint is still accepted, and is discarded.
- R10: A tag equal to the reserved value 4'hF never matches, whatever the programmed IDs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one ID into the configuration chain this cycle |
| cfg_id | input | 4 | ID value shifted in |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Word accepted at this edge if src_valid |
| src_row_tag | input | 4 | Tag compared with the row IDs |
| src_col_tag | input | 4 | Tag compared with the endpoint column IDs |
| src_data | input | 16 | Data word |
| pe_enable | input | ROWS*COLS | Per-endpoint enable; a cleared bit blocks delivery |
| ep_valid | output | ROWS*COLS | Pending word per endpoint, index r*COLS+c |
| ep_data | output | 16 | Word delivered to the valid endpoints |
| ep_ready | input | ROWS*COLS | Endpoint takes its pending word |

## Verification
The bench checks programmed IDs where rows match but column IDs do not, and the reverse. A design that matched on one level only would deliver to whole rows or whole columns. Reserved tags and reserved IDs are covered, since a design that compared them like ordinary values would deliver to endpoints that are switched off. A single endpoint that holds back while the others drain checks that the stall covers every pending endpoint. A design that stalled only on some endpoints would overwrite that endpoint's pending word. Shifting IDs while the source offers a word checks that no transfer slips through during configuration, and random ID maps mixed with random enables check the full match rule.

// File: rtl/tagcast_pkg.sv
package tagcast_pkg;

    localparam int GRID_ROWS = 12;
    localparam int GRID_COLS = 14;
    localparam int WORD_W    = 16;
    localparam int TAG_W     = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [TAG_W-1:0]  tag_t;

    // ID value that disables a controller and never matches a tag
    localparam tag_t TAG_OFF = '1;

    // routing part of a vertical bus beat
    typedef struct packed {
        tag_t row_tag;
        tag_t col_tag;
    } route_t;

    function automatic logic tag_hit(tag_t tag, tag_t id);
        return (id != TAG_OFF) && (tag == id);
    endfunction

endpackage

// File: rtl/tagcast_idchain.sv
module tagcast_idchain
    import tagcast_pkg::*;
#(
    parameter int DEPTH = 180
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift,
    input  tag_t               din,
    output tag_t [DEPTH-1:0]   ids
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ids <= {DEPTH{TAG_OFF}};
        end else if (shift) begin
            ids <= {ids[DEPTH-2:0], din};
        end
    end

endmodule

// File: rtl/tagcast_filter.sv
module tagcast_filter
    import tagcast_pkg::*;
(
    input  logic in_valid,
    input  tag_t tag,
    input  tag_t id,
    output logic out_valid
);

    assign out_valid = in_valid && tag_hit(tag, id);

endmodule

// File: rtl/tagcast_row.sv
module tagcast_row
    import tagcast_pkg::*;
#(
    parameter int COLS = 14
) (
    input  logic              bus_valid,
    input  route_t            bus,
    input  tag_t              row_id,
    input  tag_t [COLS-1:0]   col_ids,
    output logic [COLS-1:0]   hit
);

    logic hbus_valid;

    // vertical level: row tag against the row controller ID
    tagcast_filter row_ctl (
        .in_valid  (bus_valid),
        .tag       (bus.row_tag),
        .id        (row_id),
        .out_valid (hbus_valid)
    );

    // horizontal level: column tag against each endpoint controller ID
    for (genvar c = 0; c < COLS; c++) begin : g_col
        tagcast_filter col_ctl (
            .in_valid  (hbus_valid),
            .tag       (bus.col_tag),
            .id        (col_ids[c]),
            .out_valid (hit[c])
        );
    end

endmodule

// File: rtl/tagcast_grid.sv
module tagcast_grid
    import tagcast_pkg::*;
#(
    parameter int ROWS = GRID_ROWS,
    parameter int COLS = GRID_COLS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_shift,
    input  logic [TAG_W-1:0]       cfg_id,
    input  logic                   src_valid,
    output logic                   src_ready,
    input  logic [TAG_W-1:0]       src_row_tag,
    input  logic [TAG_W-1:0]       src_col_tag,
    input  logic [WORD_W-1:0]      src_data,
    input  logic [ROWS*COLS-1:0]   pe_enable,
    output logic [ROWS*COLS-1:0]   ep_valid,
    output logic [WORD_W-1:0]      ep_data,
    input  logic [ROWS*COLS-1:0]   ep_ready
);

    localparam int EP    = ROWS * COLS;
    localparam int CHAIN = ROWS + EP;

    tag_t [CHAIN-1:0] id_vec;
    route_t           route;
    logic [EP-1:0]    hit;
    logic [EP-1:0]    pend_q;
    word_t            data_q;
    logic             drain_ok;
    logic             fire;

    tagcast_idchain #(.DEPTH(CHAIN)) chain_i (
        .clk   (clk),
        .rst   (rst),
        .shift (cfg_shift),
        .din   (cfg_id),
        .ids   (id_vec)
    );

    assign route = '{row_tag: src_row_tag, col_tag: src_col_tag};

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        tagcast_row #(.COLS(COLS)) row_i (
            .bus_valid (src_valid),
            .bus       (route),
            .row_id    (id_vec[r]),
            .col_ids   (id_vec[ROWS + r*COLS +: COLS]),
            .hit       (hit[r*COLS +: COLS])
        );
    end

    // every pending word must leave this cycle before a new one may land
    assign drain_ok  = &(~pend_q | ep_ready);
    assign src_ready = drain_ok && !cfg_shift;
    assign fire      = src_valid && src_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            data_q <= '0;
        end else if (fire) begin
            pend_q <= hit & pe_enable;
            data_q <= src_data;
        end else begin
            pend_q <= pend_q & ~ep_ready;
        end
    end

    assign ep_valid = pend_q;
    assign ep_data  = data_q;

endmodule

// File: rtl/tagcast_grid_chk.sv
module tagcast_grid_chk
    import tagcast_pkg::*;
#(
    parameter int ROWS = GRID_ROWS,
    parameter int COLS = GRID_COLS
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_shift,
    input logic                   src_valid,
    input logic                   src_ready,
    input logic [ROWS*COLS-1:0]   pe_enable,
    input logic [ROWS*COLS-1:0]   ep_valid,
    input logic [WORD_W-1:0]      ep_data,
    input logic [ROWS*COLS-1:0]   ep_ready
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ep_valid == '0));

    a_r3_cfg_blocks_source: assert property (@(posedge clk) disable iff (rst)
        cfg_shift |-> !src_ready);

    a_r4_gated_no_delivery: assert property (@(posedge clk) disable iff (rst)
        (ep_valid & ~$past(ep_valid) & ~$past(pe_enable)) == '0);

    a_r6_rise_needs_accept: assert property (@(posedge clk) disable iff (rst)
        (|(ep_valid & ~$past(ep_valid))) |-> $past(src_valid && src_ready));

    a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        (|(ep_valid & ~ep_ready)) |=> (($past(ep_valid & ~ep_ready) & ~ep_valid) == '0));

    a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
        ((|ep_valid) && !(src_valid && src_ready)) |=> $stable(ep_data));

endmodule

bind tagcast_grid tagcast_grid_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_shift (cfg_shift),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .pe_enable (pe_enable),
    .ep_valid  (ep_valid),
    .ep_data   (ep_data),
    .ep_ready  (ep_ready)
);

// File: tb/tagcast_grid_tb_top.sv
`timescale 1ns/1ps
module tagcast_grid_tb_top;
    import tagcast_pkg::*;

    localparam int ROWS  = GRID_ROWS;
    localparam int COLS  = GRID_COLS;
    localparam int EP    = ROWS * COLS;
    localparam int CHAIN = ROWS + EP;

    logic clk = 1'b0;
    logic rst;
    logic cfg_shift;
    tag_t cfg_id;
    logic src_valid;
    logic src_ready;
    tag_t src_row_tag;
    tag_t src_col_tag;
    word_t src_data;
    logic [EP-1:0] pe_enable;
    logic [EP-1:0] ep_valid;
    word_t ep_data;
    logic [EP-1:0] ep_ready;

    int vectors = 0;
    int fails   = 0;
    tag_t model [CHAIN];
    tag_t img   [CHAIN];

    always #2 clk = ~clk;

    tagcast_grid dut_i (
        .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_id(cfg_id),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_row_tag(src_row_tag), .src_col_tag(src_col_tag), .src_data(src_data),
        .pe_enable(pe_enable), .ep_valid(ep_valid), .ep_data(ep_data), .ep_ready(ep_ready)
    );

    task automatic chk(input bit ok, input string req, input logic [EP-1:0] act,
                       input logic [EP-1:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic hit_m(tag_t tag, tag_t id);
        return (id != 4'hF) && (tag != 4'hF) && (tag == id);
    endfunction

    function automatic logic [EP-1:0] expect_mask(tag_t rt, tag_t ct, logic [EP-1:0] en);
        logic [EP-1:0] m;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                m[r*COLS+c] = en[r*COLS+c] && hit_m(rt, model[r]) &&
                              hit_m(ct, model[ROWS + r*COLS + c]);
        return m;
    endfunction

    // R2: shift one word; model follows the chain order
    task automatic shift_word(input tag_t w, input bit probe);
        @(negedge clk);
        cfg_shift = 1'b1;
        cfg_id    = w;
        if (probe) begin
            #1;
            chk(src_ready == 1'b0, "R3 src_ready during shift", EP'(src_ready), '0);
        end
        @(posedge clk);
        for (int p = CHAIN-1; p > 0; p--) model[p] = model[p-1];
        model[0] = w;
    endtask

    task automatic program_img(input bit probe);
        for (int k = CHAIN-1; k >= 0; k--) shift_word(img[k], probe && (k % 60 == 0));
        @(negedge clk);
        cfg_shift = 1'b0;
    endtask

    task automatic xfer(input tag_t rt, input tag_t ct, input word_t d, input string req);
        logic [EP-1:0] expm;
        @(negedge clk);
        src_valid   = 1'b1;
        src_row_tag = rt;
        src_col_tag = ct;
        src_data    = d;
        expm = expect_mask(rt, ct, pe_enable);
        #1;
        chk(src_ready == 1'b1, {req, " src_ready"}, EP'(src_ready), EP'(1));
        @(negedge clk);
        src_valid = 1'b0;
        chk(ep_valid == expm, {req, " ep_valid"}, ep_valid, expm);
        if (expm != '0)
            chk(ep_data == d, {req, " ep_data"}, EP'(ep_data), EP'(d));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_shift = 1'b0; cfg_id = '0; src_valid = 1'b0;
        src_row_tag = '0; src_col_tag = '0; src_data = '0;
        pe_enable = '1; ep_ready = '1;
        for (int p = 0; p < CHAIN; p++) model[p] = 4'hF;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(ep_valid == '0, "R1 ep_valid after reset", ep_valid, '0);
        chk(src_ready == 1'b1, "R1 src_ready after reset", EP'(src_ready), EP'(1));
        xfer(4'h0, 4'h0, 16'h1111, "R1 reserved IDs deliver nowhere");

        // R2 R3: point-to-point map, source offering a word while shifting
        for (int r = 0; r < ROWS; r++) img[r] = tag_t'(r);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) img[ROWS + r*COLS + c] = tag_t'(c);
        @(negedge clk);
        src_valid = 1'b1; src_row_tag = 4'h0; src_col_tag = 4'h0; src_data = 16'hDEAD;
        program_img(1'b1);
        src_valid = 1'b0;
        chk(ep_valid == '0, "R3 nothing delivered during shift", ep_valid, '0);
        // R5 unique IDs -> single endpoint; R2 checks chain order
        xfer(4'd5, 4'd7, 16'hA5A5, "R2 R5 point-to-point (5,7)");
        xfer(4'd0, 4'd0, 16'h0F0F, "R2 R5 point-to-point (0,0)");
        xfer(4'd11, 4'd13, 16'h1234, "R2 R5 point-to-point (11,13)");
        // R9 no match accepted and dropped; R10 reserved tag
        xfer(4'd14, 4'd3, 16'h2222, "R9 no match");
        xfer(4'd3, 4'hF, 16'h3333, "R10 reserved column tag");
        xfer(4'hF, 4'd2, 16'h4444, "R10 reserved row tag");

        // R5 multicast: all IDs shared
        for (int p = 0; p < CHAIN; p++) img[p] = 4'd2;
        program_img(1'b0);
        xfer(4'd2, 4'd2, 16'hBEEF, "R5 full multicast");
        // R4 gated endpoints
        pe_enable = '1;
        pe_enable[0] = 1'b0; pe_enable[EP-1] = 1'b0; pe_enable[50] = 1'b0;
        xfer(4'd2, 4'd2, 16'hCAFE, "R4 gated endpoints");
        pe_enable = '1;

        // R7 R8 back-pressure from one endpoint
        @(negedge clk);
        ep_ready[20] = 1'b0;
        src_valid = 1'b1; src_row_tag = 4'd2; src_col_tag = 4'd2; src_data = 16'h0A0A;
        @(negedge clk);
        chk(ep_valid == '1, "R6 word after accept", ep_valid, '1);
        src_data = 16'h0B0B;
        #1;
        chk(src_ready == 1'b0, "R8 stall on held endpoint", EP'(src_ready), '0);
        @(negedge clk);
        chk(ep_valid == (EP'(1) << 20), "R7 held endpoint keeps valid", ep_valid, EP'(1) << 20);
        chk(ep_data == 16'h0A0A, "R7 held data stable", EP'(ep_data), EP'(16'h0A0A));
        ep_ready[20] = 1'b1;
        #1;
        chk(src_ready == 1'b1, "R8 ready once all drain", EP'(src_ready), EP'(1));
        @(negedge clk);
        src_valid = 1'b0;
        chk(ep_valid == '1, "R8 next word lands", ep_valid, '1);
        chk(ep_data == 16'h0B0B, "R8 next word data", EP'(ep_data), EP'(16'h0B0B));

        // R4 random maps, tags and enables
        for (int round = 0; round < 4; round++) begin
            for (int p = 0; p < CHAIN; p++) begin
                int v = $urandom_range(0, 4);
                img[p] = (v == 4) ? 4'hF : tag_t'(v);
            end
            program_img(1'b0);
            for (int n = 0; n < 80; n++) begin
                tag_t rt;
                tag_t ct;
                for (int e = 0; e < EP; e++) pe_enable[e] = ($urandom_range(0, 7) != 0);
                rt = ($urandom_range(0, 9) == 0) ? 4'hF : tag_t'($urandom_range(0, 3));
                ct = ($urandom_range(0, 9) == 0) ? 4'hF : tag_t'($urandom_range(0, 3));
                xfer(rt, ct, word_t'($urandom), "R4 random match");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule